// File: doc/BRIEF.md
# Dual-Clock Bulk-Swap Register File Pair

Two small register files, one owned by each of two cores whose clocks are unrelated, cooperate to move architectural state from one core to the other. While a core's migration window is open, it fills its own file in its own clock domain. The entry is selected by logical register number, and a dedicated port loads the exception-PC slot. Outside that window the file's clock and write inputs are shut off.

When both cores have raised their done flags, a controller on a third, common clock steers both file clocks over to itself through glitch-free clock selectors. It then exchanges every entry of the two files on a single edge and hands the clocks back. Each core is told through a one-cycle pulse in its own domain. Afterwards each core reads its file combinationally by logical register number, to write the value back into its own pipeline.

Top module: `rf_swap_pair`

## Requirements
- R1: Each file holds NREG+1 entries of DW bits. Indices 0 to NREG-1 are the logical registers, and index NREG is the exception-PC slot. Reset clears every entry of both files to zero.
- R2: While mig_k is high, a core-side write with wr_en_k high stores wr_data_k in entry wr_idx_k of file k. An index above NREG is ignored and changes no entry.
- R3: epc_wr_k with mig_k high stores epc_data_k in entry NREG. If a general write targets index NREG in the same cycle, the exception-PC port wins.
- R4: Writes presented while mig_k is low have no effect on the file.
- R5: No exchange takes place while only one of done0 and done1 is high.
- R6: An exchange swaps every entry, including entries not written in the current migration. Afterwards file 0 holds exactly the former contents of file 1, and file 1 holds the former contents of file 0.
- R7: Each exchange produces exactly one swapped_k pulse, one core-clock cycle wide, in each core's domain.
- R8: After an exchange, no further exchange starts until each done flag has been seen low. Done flags held high after the pulse do not repeat the exchange.
- R9: rd_data_k returns entry rd_idx_k when rd_en_k is high and rd_idx_k is at most NREG. Otherwise it returns zero.
- R10: No file clock selector ever enables its core clock and the common clock together, and the exchange edge occurs only while both files run on the common clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_x | input | 1 | Common clock used for the exchange |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_c0 | input | 1 | Core 0 clock |
| mig0 | input | 1 | Core 0 migration window open |
| wr_en0 | input | 1 | Core 0 register write strobe |
| wr_idx0 | input | IW | Core 0 write logical register number |
| wr_data0 | input | DW | Core 0 write value |
| epc_wr0 | input | 1 | Core 0 exception-PC write strobe |
| epc_data0 | input | DW | Core 0 exception-PC value |
| done0 | input | 1 | Core 0 has finished its writes |
| rd_en0 | input | 1 | Core 0 read enable |
| rd_idx0 | input | IW | Core 0 read logical register number |
| rd_data0 | output | DW | Core 0 read value |
| swapped0 | output | 1 | Exchange-complete pulse in core 0 domain |
| clk_c1 | input | 1 | Core 1 clock |
| mig1 | input | 1 | Core 1 migration window open |
| wr_en1 | input | 1 | Core 1 register write strobe |
| wr_idx1 | input | IW | Core 1 write logical register number |
| wr_data1 | input | DW | Core 1 write value |
| epc_wr1 | input | 1 | Core 1 exception-PC write strobe |
| epc_data1 | input | DW | Core 1 exception-PC value |
| done1 | input | 1 | Core 1 has finished its writes |
| rd_en1 | input | 1 | Core 1 read enable |
| rd_idx1 | input | IW | Core 1 read logical register number |
| rd_data1 | output | DW | Core 1 read value |
| swapped1 | output | 1 | Exchange-complete pulse in core 1 domain |

## Verification
On every cycle, the bound checker watches the clock selectors and the controller. It confirms that neither selector enables both sources at once, that the exchange strobe lasts one cycle and only fires while both files sit on the common clock, that an exchange starts only from two synchronized done flags, and that completion pulses are one core cycle wide. Only the bench scenarios can show what the files actually contain. These scenarios cover write priority, out-of-range and out-of-window writes being ignored, the value-by-value result of repeated exchanges including untouched entries, and the absence of an exchange under a single done flag or under done flags held high after a swap.

// File: rtl/rfx_pkg.sv
`timescale 1ns/1ps
package rfx_pkg;
   typedef enum logic [2:0] {
      X_IDLE = 3'd0,
      X_GRAB = 3'd1,
      X_XCHG = 3'd2,
      X_REL  = 3'd3,
      X_ACK  = 3'd4
   } xfer_state_t;
endpackage

// File: rtl/rfx_sync.sv
`timescale 1ns/1ps
module rfx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rfx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rfx_clk_sel.sv
`timescale 1ns/1ps
module rfx_clk_sel (
   input  logic clk_a,
   input  logic clk_b,
   input  logic rst_n,
   input  logic req_a,
   input  logic req_b,
   output logic clk_o,
   output logic a_on,
   output logic b_on
);
   logic a_q1, a_q2, a_en;
   logic b_q1, b_q2, b_en;

   always_ff @(posedge clk_a or negedge rst_n) begin
      if (!rst_n) begin
         a_q1 <= 1'b0;
         a_q2 <= 1'b0;
      end else begin
         a_q1 <= req_a & ~req_b & ~b_en;
         a_q2 <= a_q1;
      end
   end

   always_ff @(negedge clk_a or negedge rst_n) begin
      if (!rst_n) a_en <= 1'b0;
      else        a_en <= a_q2;
   end

   always_ff @(posedge clk_b or negedge rst_n) begin
      if (!rst_n) begin
         b_q1 <= 1'b0;
         b_q2 <= 1'b0;
      end else begin
         b_q1 <= req_b & ~a_en;
         b_q2 <= b_q1;
      end
   end

   always_ff @(negedge clk_b or negedge rst_n) begin
      if (!rst_n) b_en <= 1'b0;
      else        b_en <= b_q2;
   end

   assign clk_o = (clk_a & a_en) | (clk_b & b_en);
   assign a_on  = a_en;
   assign b_on  = b_en;
endmodule

// File: rtl/rfx_bank.sv
`timescale 1ns/1ps
module rfx_bank #(
   parameter  int NREG = 32,
   parameter  int DW   = 32,
   localparam int NENT = NREG + 1,
   localparam int IW   = $clog2(NENT)
) (
   input  logic                      clk_f,
   input  logic                      rst_n,
   input  logic                      on_x,
   input  logic                      swap_en,
   input  logic                      wr_en,
   input  logic [IW-1:0]             wr_idx,
   input  logic [DW-1:0]             wr_data,
   input  logic                      epc_wr,
   input  logic [DW-1:0]             epc_data,
   input  logic [NENT-1:0][DW-1:0]   peer,
   output logic [NENT-1:0][DW-1:0]   img,
   input  logic                      rd_en,
   input  logic [IW-1:0]             rd_idx,
   output logic [DW-1:0]             rd_data
);
   localparam logic [IW-1:0] LAST = IW'(NREG);

   logic [NENT-1:0][DW-1:0] mem;

   always_ff @(posedge clk_f or negedge rst_n) begin
      if (!rst_n) begin
         mem <= '0;
      end else if (on_x) begin
         if (swap_en) mem <= peer;
      end else begin
         if (wr_en && (wr_idx <= LAST)) mem[wr_idx] <= wr_data;
         if (epc_wr)                    mem[NREG]   <= epc_data;
      end
   end

   assign img     = mem;
   assign rd_data = (rd_en && (rd_idx <= LAST)) ? mem[rd_idx] : '0;
endmodule

// File: rtl/rf_swap_pair.sv
`timescale 1ns/1ps
module rf_swap_pair
   import rfx_pkg::*;
#(
   parameter  int NREG = 32,
   parameter  int DW   = 32,
   localparam int NENT = NREG + 1,
   localparam int IW   = $clog2(NENT)
) (
   input  logic          clk_x,
   input  logic          rst_n,
   input  logic          clk_c0,
   input  logic          mig0,
   input  logic          wr_en0,
   input  logic [IW-1:0] wr_idx0,
   input  logic [DW-1:0] wr_data0,
   input  logic          epc_wr0,
   input  logic [DW-1:0] epc_data0,
   input  logic          done0,
   input  logic          rd_en0,
   input  logic [IW-1:0] rd_idx0,
   output logic [DW-1:0] rd_data0,
   output logic          swapped0,
   input  logic          clk_c1,
   input  logic          mig1,
   input  logic          wr_en1,
   input  logic [IW-1:0] wr_idx1,
   input  logic [DW-1:0] wr_data1,
   input  logic          epc_wr1,
   input  logic [DW-1:0] epc_data1,
   input  logic          done1,
   input  logic          rd_en1,
   input  logic [IW-1:0] rd_idx1,
   output logic [DW-1:0] rd_data1,
   output logic          swapped1
);
   if (NREG < 2) begin : g_bad_nreg
      $error("rf_swap_pair: NREG must be at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("rf_swap_pair: DW must be at least 1");
   end

   logic [1:0]              clk_c, mig, wr_en, epc_wr, done_c, rd_en;
   logic [1:0]              clk_f, en_core, on_x, dn_x, sw_pulse;
   logic [IW-1:0]           wr_idx [2];
   logic [IW-1:0]           rd_idx [2];
   logic [DW-1:0]           wr_data [2];
   logic [DW-1:0]           epc_data [2];
   logic [DW-1:0]           rd_data [2];
   logic [NENT-1:0][DW-1:0] img [2];

   assign clk_c  = {clk_c1, clk_c0};
   assign mig    = {mig1, mig0};
   assign wr_en  = {wr_en1, wr_en0};
   assign epc_wr = {epc_wr1, epc_wr0};
   assign done_c = {done1, done0};
   assign rd_en  = {rd_en1, rd_en0};
   assign wr_idx[0]   = wr_idx0;
   assign wr_idx[1]   = wr_idx1;
   assign rd_idx[0]   = rd_idx0;
   assign rd_idx[1]   = rd_idx1;
   assign wr_data[0]  = wr_data0;
   assign wr_data[1]  = wr_data1;
   assign epc_data[0] = epc_data0;
   assign epc_data[1] = epc_data1;
   assign rd_data0 = rd_data[0];
   assign rd_data1 = rd_data[1];
   assign swapped0 = sw_pulse[0];
   assign swapped1 = sw_pulse[1];

   // exchange controller on the common clock
   xfer_state_t state, nxt;
   logic        sel_r, tog_x;
   logic [1:0]  lo_seen;
   logic        swap_en;

   assign swap_en = (state == X_XCHG);

   always_comb begin
      nxt = state;
      case (state)
         X_IDLE: if (dn_x[0] && dn_x[1])               nxt = X_GRAB;
         X_GRAB: if (on_x[0] && on_x[1])               nxt = X_XCHG;
         X_XCHG:                                        nxt = X_REL;
         X_REL:  if (!on_x[0] && !on_x[1])             nxt = X_ACK;
         X_ACK:  if (&(lo_seen | ~dn_x))               nxt = X_IDLE;
         default:                                       nxt = X_IDLE;
      endcase
   end

   always_ff @(posedge clk_x or negedge rst_n) begin
      if (!rst_n) begin
         state   <= X_IDLE;
         sel_r   <= 1'b0;
         tog_x   <= 1'b0;
         lo_seen <= '0;
      end else begin
         state <= nxt;
         sel_r <= (nxt == X_GRAB) || (nxt == X_XCHG);
         if (state == X_REL && nxt == X_ACK) tog_x <= ~tog_x;
         if (state == X_ACK) lo_seen <= (nxt == X_IDLE) ? '0 : (lo_seen | ~dn_x);
      end
   end

   for (genvar k = 0; k < 2; k++) begin : g_side
      logic tog_c, tog_d;

      rfx_clk_sel u_csel (
         .clk_a (clk_c[k]),
         .clk_b (clk_x),
         .rst_n (rst_n),
         .req_a (mig[k] & ~sel_r),
         .req_b (sel_r),
         .clk_o (clk_f[k]),
         .a_on  (en_core[k]),
         .b_on  (on_x[k])
      );

      rfx_bank #(.NREG(NREG), .DW(DW)) u_bank (
         .clk_f    (clk_f[k]),
         .rst_n    (rst_n),
         .on_x     (on_x[k]),
         .swap_en  (swap_en),
         .wr_en    (wr_en[k] & mig[k]),
         .wr_idx   (wr_idx[k]),
         .wr_data  (wr_data[k]),
         .epc_wr   (epc_wr[k] & mig[k]),
         .epc_data (epc_data[k]),
         .peer     (img[1-k]),
         .img      (img[k]),
         .rd_en    (rd_en[k]),
         .rd_idx   (rd_idx[k]),
         .rd_data  (rd_data[k])
      );

      rfx_sync #(.STAGES(2)) u_dn_sync (
         .clk (clk_x), .rst_n (rst_n), .d (done_c[k]), .q (dn_x[k])
      );

      rfx_sync #(.STAGES(2)) u_tg_sync (
         .clk (clk_c[k]), .rst_n (rst_n), .d (tog_x), .q (tog_c)
      );

      always_ff @(posedge clk_c[k] or negedge rst_n) begin
         if (!rst_n) tog_d <= 1'b0;
         else        tog_d <= tog_c;
      end

      assign sw_pulse[k] = tog_c ^ tog_d;
   end
endmodule

// File: rtl/rf_swap_pair_chk.sv
`timescale 1ns/1ps
module rf_swap_pair_chk (
   input logic       clk_x,
   input logic       rst_n,
   input logic       clk_c0,
   input logic       clk_c1,
   input logic       sel_r,
   input logic       swap_en,
   input logic       tog_x,
   input logic [1:0] on_x,
   input logic [1:0] en_core,
   input logic [1:0] dn_x,
   input logic [1:0] sw_pulse
);
   a_r10_src_excl0: assert property (@(posedge clk_x) disable iff (!rst_n)
      !(en_core[0] && on_x[0]));

   a_r10_src_excl1: assert property (@(posedge clk_x) disable iff (!rst_n)
      !(en_core[1] && on_x[1]));

   a_r10_swap_on_common: assert property (@(posedge clk_x) disable iff (!rst_n)
      swap_en |-> (on_x[0] && on_x[1]));

   a_r6_swap_single: assert property (@(posedge clk_x) disable iff (!rst_n)
      swap_en |=> !swap_en);

   a_r5_start_needs_both: assert property (@(posedge clk_x) disable iff (!rst_n)
      $rose(sel_r) |-> $past(dn_x[0] && dn_x[1]));

   a_r7_tog_after_release: assert property (@(posedge clk_x) disable iff (!rst_n)
      !$stable(tog_x) |-> (!on_x[0] && !on_x[1]));

   a_r7_pulse_width0: assert property (@(posedge clk_c0) disable iff (!rst_n)
      sw_pulse[0] |=> !sw_pulse[0]);

   a_r7_pulse_width1: assert property (@(posedge clk_c1) disable iff (!rst_n)
      sw_pulse[1] |=> !sw_pulse[1]);
endmodule

bind rf_swap_pair rf_swap_pair_chk u_chk (
   .clk_x    (clk_x),
   .rst_n    (rst_n),
   .clk_c0   (clk_c0),
   .clk_c1   (clk_c1),
   .sel_r    (sel_r),
   .swap_en  (swap_en),
   .tog_x    (tog_x),
   .on_x     (on_x),
   .en_core  (en_core),
   .dn_x     (dn_x),
   .sw_pulse (sw_pulse)
);

// File: tb/rf_swap_pair_test.sv
`timescale 1ns/1ps
module rf_swap_pair_test;
   localparam int NREG = 8;
   localparam int DW   = 16;
   localparam int NENT = NREG + 1;
   localparam int IW   = $clog2(NENT);

   logic clk_x = 0, clk_c0 = 0, clk_c1 = 0, rst_n = 0;
   logic mig0 = 0, wr_en0 = 0, epc_wr0 = 0, done0 = 0, rd_en0 = 0;
   logic mig1 = 0, wr_en1 = 0, epc_wr1 = 0, done1 = 0, rd_en1 = 0;
   logic [IW-1:0] wr_idx0 = 0, rd_idx0 = 0, wr_idx1 = 0, rd_idx1 = 0;
   logic [DW-1:0] wr_data0 = 0, epc_data0 = 0, wr_data1 = 0, epc_data1 = 0;
   logic [DW-1:0] rd_data0, rd_data1;
   logic swapped0, swapped1;

   always #10 clk_x  = ~clk_x;
   always #7  clk_c0 = ~clk_c0;
   always #13 clk_c1 = ~clk_c1;

   rf_swap_pair #(.NREG(NREG), .DW(DW)) uut (
      .clk_x(clk_x), .rst_n(rst_n),
      .clk_c0(clk_c0), .mig0(mig0), .wr_en0(wr_en0), .wr_idx0(wr_idx0),
      .wr_data0(wr_data0), .epc_wr0(epc_wr0), .epc_data0(epc_data0),
      .done0(done0), .rd_en0(rd_en0), .rd_idx0(rd_idx0), .rd_data0(rd_data0),
      .swapped0(swapped0),
      .clk_c1(clk_c1), .mig1(mig1), .wr_en1(wr_en1), .wr_idx1(wr_idx1),
      .wr_data1(wr_data1), .epc_wr1(epc_wr1), .epc_data1(epc_data1),
      .done1(done1), .rd_en1(rd_en1), .rd_idx1(rd_idx1), .rd_data1(rd_data1),
      .swapped1(swapped1)
   );

   int checks = 0, errors = 0, cyc = 0;
   int cnt0 = 0, cnt1 = 0;
   bit finished = 0;
   logic [DW-1:0] model [2][NENT];

   always @(posedge clk_c0) if (swapped0) cnt0++;
   always @(posedge clk_c1) if (swapped1) cnt1++;

   always @(posedge clk_x) begin
      cyc++;
      if (cyc == 150000 && !finished) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic logic [DW-1:0] pat(int s, int i, int r);
      return DW'(16'h1000 * (s + 1) + 16'h0100 * r + i * 7 + 3);
   endfunction

   task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(int s, logic en, int idx, output logic [DW-1:0] v);
      if (s == 0) begin rd_en0 = en; rd_idx0 = IW'(idx); end
      else        begin rd_en1 = en; rd_idx1 = IW'(idx); end
      #1;
      v = (s == 0) ? rd_data0 : rd_data1;
      rd_en0 = 0; rd_en1 = 0;
   endtask

   task automatic cmp_all(string req);
      logic [DW-1:0] v;
      for (int s = 0; s < 2; s++)
         for (int i = 0; i < NENT; i++) begin
            rd(s, 1'b1, i, v);
            chk(req, v, model[s][i]);
         end
   endtask

   task automatic wr(int s, int idx, logic [DW-1:0] d);
      if (s == 0) begin
         @(negedge clk_c0); wr_en0 = 1; wr_idx0 = IW'(idx); wr_data0 = d;
         @(negedge clk_c0); wr_en0 = 0;
         if (mig0 && idx <= NREG) model[0][idx] = d;
      end else begin
         @(negedge clk_c1); wr_en1 = 1; wr_idx1 = IW'(idx); wr_data1 = d;
         @(negedge clk_c1); wr_en1 = 0;
         if (mig1 && idx <= NREG) model[1][idx] = d;
      end
   endtask

   task automatic wr_epc(int s, logic [DW-1:0] d);
      if (s == 0) begin
         @(negedge clk_c0); epc_wr0 = 1; epc_data0 = d;
         @(negedge clk_c0); epc_wr0 = 0;
         if (mig0) model[0][NREG] = d;
      end else begin
         @(negedge clk_c1); epc_wr1 = 1; epc_data1 = d;
         @(negedge clk_c1); epc_wr1 = 0;
         if (mig1) model[1][NREG] = d;
      end
   endtask

   task automatic open_window();
      @(negedge clk_x); mig0 = 1; mig1 = 1;
      repeat (8) @(negedge clk_c1);
   endtask

   task automatic close_window();
      @(negedge clk_x); mig0 = 0; mig1 = 0;
      repeat (8) @(negedge clk_c1);
   endtask

   task automatic exchange_model();
      for (int i = 0; i < NENT; i++) begin
         logic [DW-1:0] t;
         t = model[0][i]; model[0][i] = model[1][i]; model[1][i] = t;
      end
   endtask

   // raise both dones, wait for both pulses, then optionally drop dones
   task automatic do_swap(bit drop);
      int c0, c1, n;
      c0 = cnt0; c1 = cnt1; n = 0;
      @(negedge clk_c0); done0 = 1;
      @(negedge clk_c1); done1 = 1;
      while ((cnt0 == c0 || cnt1 == c1) && n < 3000) begin
         @(posedge clk_x); n++;
      end
      repeat (6) @(negedge clk_c1);
      exchange_model();
      chk("R7 one pulse core0", DW'(cnt0 - c0), DW'(1));
      chk("R7 one pulse core1", DW'(cnt1 - c1), DW'(1));
      if (drop) begin
         done0 = 0; done1 = 0;
         repeat (20) @(negedge clk_x);
      end
   endtask

   initial begin
      logic [DW-1:0] v;
      int c0, c1;
      for (int s = 0; s < 2; s++)
         for (int i = 0; i < NENT; i++) model[s][i] = '0;

      repeat (3) @(negedge clk_x);
      rst_n = 1;
      repeat (3) @(negedge clk_x);

      // R1 / reset: all entries zero
      cmp_all("R1 reset clear");

      // R9: read gating and out-of-range index
      rd(0, 1'b0, 2, v); chk("R9 rd_en low", v, '0);
      rd(1, 1'b1, 12, v); chk("R9 index above NREG", v, '0);

      // round 0: full fill
      open_window();
      for (int s = 0; s < 2; s++) begin
         for (int i = 0; i < NREG; i++) wr(s, i, pat(s, i, 0));
         wr_epc(s, pat(s, 15, 0));
      end
      // R2: out-of-range write ignored
      wr(0, 13, 16'hDEAD);
      wr(1, NREG + 1, 16'hBEEF);
      // R3: same-cycle general and exception-PC write to slot NREG
      @(negedge clk_c0);
      wr_en0 = 1; wr_idx0 = IW'(NREG); wr_data0 = 16'h5555;
      epc_wr0 = 1; epc_data0 = 16'hA0A0;
      @(negedge clk_c0); wr_en0 = 0; epc_wr0 = 0;
      model[0][NREG] = 16'hA0A0;
      close_window();
      // R4: writes while window closed
      wr(1, 3, 16'h7777);
      wr_epc(0, 16'h6666);
      cmp_all("R2 R3 R4 contents before exchange");

      // R5: single done does not start an exchange
      c0 = cnt0; c1 = cnt1;
      @(negedge clk_c0); done0 = 1;
      repeat (80) @(negedge clk_x);
      chk("R5 no pulse core0", DW'(cnt0 - c0), '0);
      chk("R5 no pulse core1", DW'(cnt1 - c1), '0);
      cmp_all("R5 contents unchanged");
      done0 = 0;
      repeat (10) @(negedge clk_x);

      // R6: exchange
      do_swap(1'b1);
      cmp_all("R6 first exchange");

      // round 1: partial fill then exchange with dones held high
      open_window();
      for (int s = 0; s < 2; s++)
         for (int i = 0; i < NREG; i += 2) wr(s, i, pat(s, i, 1));
      close_window();
      do_swap(1'b0);
      cmp_all("R6 partial exchange");
      // R8: held dones must not repeat the exchange
      c0 = cnt0; c1 = cnt1;
      repeat (100) @(negedge clk_x);
      chk("R8 no repeat core0", DW'(cnt0 - c0), '0);
      chk("R8 no repeat core1", DW'(cnt1 - c1), '0);
      cmp_all("R8 contents stable");
      done0 = 0; done1 = 0;
      repeat (20) @(negedge clk_x);

      // round 2: no writes, pure exchange back after dones dropped (R8)
      do_swap(1'b1);
      cmp_all("R8 R6 exchange after release");

      // round 3: overwrite exception-PC slots only
      open_window();
      wr_epc(0, pat(0, 9, 3));
      wr_epc(1, pat(1, 9, 3));
      close_window();
      do_swap(1'b1);
      cmp_all("R3 R6 epc exchange");

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule